// File: doc/BRIEF.md
# Lockable External-Bus Region Configuration Bank

This block holds the set-up of a parameterised number of external-bus chip-select regions (four by default). Each region owns one 8-bit control word that picks its data width, whether writes to the region are allowed, whether it runs synchronously, and how many wait states it inserts. The decoded settings leave the block on per-region output vectors for a memory timing engine to use.

All control words sit behind a single guard register. The bank leaves reset guarded. Software opens it by writing one exact key word to the guard register. Any other value written there closes it again. While the bank is guarded, writes to control words are dropped. Software can read a control word back to see whether its write was refused.

Access is through a simple synchronous register port. A request with the write flag set takes effect at the clock edge where it is sampled. A read request returns its data on the registered read bus one cycle later.

Top module: `xbus_cfg_bank`

## Requirements
- R1: After reset the bank is guarded (`bank_locked` = 1 and the guard register reads 1), and every control word reads the reset default 0xF2.
- R2: Writing exactly 0x0000A05F to the guard register (byte offset 0x20) opens the bank. The guard register then reads 0 and `bank_locked` is 0 from the next cycle.
- R3: Writing any other value to the guard register, including 0, 1 and 0x0001A05F, leaves the bank guarded.
- R4: While the bank is open, a write to region i's control word (byte offset 4*i) stores write-data bits [7:0]. Read-back returns those bits with bits [31:8] as zero.
- R5: While the bank is guarded, a write to a control word leaves that word and all region outputs unchanged.
- R6: The width output per region (2 bits) equals control bits [1:0] for codes 0 (8-bit), 1 (16-bit) and 2 (32-bit). The reserved code 3 is stored as written, and the output shows 2.
- R7: The wait output per region (5 bits) equals control bits [7:4] plus 2, which gives a range of 2 to 17.
- R8: The write-enable output of a region follows control bit 2, and its synchronous-mode output follows bit 3.
- R9: A read at an offset that is not decoded returns 0. This covers misaligned offsets, the gap between the last region and the guard register, and offsets above it. A write to such an offset changes no control word and leaves the guard state as it was.
- R10: Read data for a request sampled at one clock edge appears on `bus_rdata` after that edge. It reflects the state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bank_locked | output | 1 | 1 while control writes are refused |
| rgn_width | output | 2*NUM_RGN | Per-region width code (0/1/2) |
| rgn_wen | output | NUM_RGN | Per-region write enable |
| rgn_sync | output | NUM_RGN | Per-region synchronous mode |
| rgn_wait | output | 5*NUM_RGN | Per-region wait-state count |

## Verification
The bench builds the bank with its defaults: four regions, key 0xA05F, reset word 0xF2 and guard offset 0x20. With these values, every region offset can be reached, along with the guard register and the undecoded gap from 0x10 to 0x1C between them. The wait field can be driven to both ends of its range (2 and 17). The reserved width code can be written, and keys that differ from the real one only in their upper bits can be tried.

// File: rtl/xbus_cfg_pkg.sv
package xbus_cfg_pkg;
  localparam int CTRL_W = 8;
  localparam int WIDTH_OUT_W = 2;
  localparam int WAIT_OUT_W = 5;

  typedef struct packed {
    logic [3:0] ws_code;
    logic       sync_mode;
    logic       wr_allow;
    logic [1:0] width_code;
  } ctrl_t;

  // Reserved code 3 is shown as the widest setting.
  function automatic logic [WIDTH_OUT_W-1:0] width_decode(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [WAIT_OUT_W-1:0] wait_count(input logic [3:0] code);
    return {1'b0, code} + 5'd2;
  endfunction
endpackage

// File: rtl/xbus_cfg_decode.sv
module xbus_cfg_decode #(
  parameter int ADDR_W = 8,
  parameter int NUM_RGN = 4,
  parameter logic [ADDR_W-1:0] GUARD_OFFS = 8'h20
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_RGN-1:0] rgn_hit,
  output logic               guard_hit,
  output logic               miss
);
  genvar g;
  generate
    for (g = 0; g < NUM_RGN; g++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(4 * g);
      assign rgn_hit[g] = (addr == OFFS);
    end
  endgenerate

  assign guard_hit = (addr == GUARD_OFFS);
  assign miss      = !guard_hit && (rgn_hit == '0);
endmodule

// File: rtl/xbus_cfg_guard.sv
module xbus_cfg_guard #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b1;
    else if (guard_wr) locked <= (wdata != KEY);
  end
endmodule

// File: rtl/xbus_cfg_region.sv
module xbus_cfg_region
  import xbus_cfg_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_VAL = 8'hF2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CTRL_W-1:0]      wdata,
  output logic [CTRL_W-1:0]      ctrl,
  output logic [WIDTH_OUT_W-1:0] width,
  output logic                   wen,
  output logic                   sync,
  output logic [WAIT_OUT_W-1:0]  waits
);
  ctrl_t word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= ctrl_t'(RST_VAL);
    else if (wr_en) word <= ctrl_t'(wdata);
  end

  assign ctrl  = word;
  assign width = width_decode(word.width_code);
  assign wen   = word.wr_allow;
  assign sync  = word.sync_mode;
  assign waits = wait_count(word.ws_code);
endmodule

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
  import xbus_cfg_pkg::*;
#(
  parameter int NUM_RGN = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] GUARD_OFFS = 8'h20,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_A05F,
  parameter logic [CTRL_W-1:0] RST_VAL = 8'hF2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_req,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic                           bank_locked,
  output logic [WIDTH_OUT_W*NUM_RGN-1:0] rgn_width,
  output logic [NUM_RGN-1:0]             rgn_wen,
  output logic [NUM_RGN-1:0]             rgn_sync,
  output logic [WAIT_OUT_W*NUM_RGN-1:0]  rgn_wait
);
  localparam int CTRL_FLAT_W = CTRL_W * NUM_RGN;

  logic [NUM_RGN-1:0]     rgn_hit;
  logic                   guard_hit;
  logic                   addr_miss;
  logic                   locked;
  logic [CTRL_FLAT_W-1:0] ctrl_flat;
  logic [DATA_W-1:0]      rd_next;

  // Named events for the checker.
  logic                   wr_evt;
  logic                   rd_evt;
  logic                   guard_wr;
  logic [NUM_RGN-1:0]     ctrl_wr;
  logic                   ctrl_wr_any;

  assign wr_evt      = bus_req && bus_we;
  assign rd_evt      = bus_req && !bus_we;
  assign guard_wr    = wr_evt && guard_hit;
  assign ctrl_wr     = (wr_evt && !locked) ? rgn_hit : '0;
  assign ctrl_wr_any = |ctrl_wr;

  xbus_cfg_decode #(
    .ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .GUARD_OFFS(GUARD_OFFS)
  ) u_dec (
    .addr(bus_addr), .rgn_hit(rgn_hit), .guard_hit(guard_hit), .miss(addr_miss)
  );

  xbus_cfg_guard #(.DATA_W(DATA_W), .KEY(KEY)) u_guard (
    .clk(clk), .rst_n(rst_n), .guard_wr(guard_wr), .wdata(bus_wdata), .locked(locked)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_RGN; g++) begin : g_rgn
      xbus_cfg_region #(.RST_VAL(RST_VAL)) u_rgn (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(ctrl_wr[g]),
        .wdata(bus_wdata[CTRL_W-1:0]),
        .ctrl(ctrl_flat[g*CTRL_W +: CTRL_W]),
        .width(rgn_width[g*WIDTH_OUT_W +: WIDTH_OUT_W]),
        .wen(rgn_wen[g]),
        .sync(rgn_sync[g]),
        .waits(rgn_wait[g*WAIT_OUT_W +: WAIT_OUT_W])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (guard_hit) rd_next[0] = locked;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (rgn_hit[i]) rd_next[CTRL_W-1:0] = rd_next[CTRL_W-1:0] | ctrl_flat[i*CTRL_W +: CTRL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_evt) bus_rdata <= rd_next;
  end

  assign bank_locked = locked;
endmodule

// File: rtl/xbus_cfg_chk.sv
module xbus_cfg_chk #(
  parameter int NUM_RGN = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_A05F
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_evt,
  input logic                    rd_evt,
  input logic                    guard_wr,
  input logic                    ctrl_wr_any,
  input logic                    addr_miss,
  input logic                    locked,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [8*NUM_RGN-1:0]    ctrl_flat,
  input logic [2*NUM_RGN-1:0]    rgn_width,
  input logic [5*NUM_RGN-1:0]    rgn_wait
);
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && (bus_wdata == KEY) |=> !locked);

  p_other_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr && (bus_wdata != KEY) |=> locked);

  p_guarded_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && locked |=> $stable(ctrl_flat));

  p_ctrl_change_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_flat) |-> $past(ctrl_wr_any && !locked));

  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt && addr_miss |=> bus_rdata == '0);

  p_miss_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && addr_miss |=> $stable(ctrl_flat) && $stable(locked));

  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        p_width_legal_r6: assert (rgn_width[2*i +: 2] != 2'd3);
        p_wait_range_r7: assert (rgn_wait[5*i +: 5] >= 5'd2 && rgn_wait[5*i +: 5] <= 5'd17);
      end
    end
  end
endmodule

bind xbus_cfg_bank xbus_cfg_chk #(.NUM_RGN(NUM_RGN), .DATA_W(DATA_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .guard_wr(guard_wr),
  .ctrl_wr_any(ctrl_wr_any), .addr_miss(addr_miss), .locked(locked),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_flat(ctrl_flat),
  .rgn_width(rgn_width), .rgn_wait(rgn_wait)
);

// File: tb/xbus_cfg_bank_tb_top.sv
module xbus_cfg_bank_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bank_locked;
  logic [2*N-1:0] rgn_width;
  logic [N-1:0] rgn_wen;
  logic [N-1:0] rgn_sync;
  logic [5*N-1:0] rgn_wait;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  logic [7:0] m_ctrl [N];
  logic m_locked;

  always #2 clk = ~clk;

  xbus_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bank_locked(bank_locked), .rgn_width(rgn_width), .rgn_wen(rgn_wen),
    .rgn_sync(rgn_sync), .rgn_wait(rgn_wait)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard one cycle after each sampled read.
  always @(posedge clk) begin
    if (rst_n && bus_req && !bus_we) begin
      #1;
      if (sb_q.size() == 0) begin
        check("R10 empty scoreboard", 32'h1, 32'h0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h20) return {31'b0, m_locked};
    for (int i = 0; i < N; i++) if (a == 8'(4 * i)) return {24'b0, m_ctrl[i]};
    return 32'h0;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 8'h20) m_locked = (d != 32'h0000A05F);
    else for (int i = 0; i < N; i++) if (a == 8'(4 * i) && !m_locked) m_ctrl[i] = d[7:0];
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = model_read(a);
    it.tag = tag;
    sb_q.push_back(it);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic check_region_outs(input int i, input string tag);
    logic [1:0] w;
    @(negedge clk);
    w = (m_ctrl[i][1:0] == 2'b11) ? 2'd2 : m_ctrl[i][1:0];
    check({tag, " R6 width"}, 32'(rgn_width[2*i +: 2]), 32'(w));
    check({tag, " R7 wait"}, 32'(rgn_wait[5*i +: 5]), 32'(m_ctrl[i][7:4]) + 32'd2);
    check({tag, " R8 wen"}, 32'(rgn_wen[i]), 32'(m_ctrl[i][2]));
    check({tag, " R8 sync"}, 32'(rgn_sync[i]), 32'(m_ctrl[i][3]));
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < N; i++) bus_read(8'(4 * i), tag);
    bus_read(8'h20, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_ctrl[i] = 8'hF2;
    m_locked = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 bank_locked", 32'(bank_locked), 32'h1);
    read_all("R1 reset read");
    for (int i = 0; i < N; i++) check_region_outs(i, "R1 reset outs");

    // R5: guarded writes refused
    bus_write(8'h00, 32'h15);
    bus_write(8'h0C, 32'h00);
    read_all("R5 guarded write");
    check_region_outs(0, "R5");

    // R2: exact key opens
    bus_write(8'h20, 32'h0000A05F);
    @(negedge clk);
    check("R2 bank_locked", 32'(bank_locked), 32'h0);
    bus_read(8'h20, "R2 guard read");

    // R4, R6, R7, R8: stores and decoded outputs
    bus_write(8'h00, 32'hFFFF_FF37);
    bus_write(8'h04, 32'h0000_0015);
    bus_write(8'h08, 32'h0000_000B);
    bus_write(8'h0C, 32'h0000_00F0);
    read_all("R4 open write");
    for (int i = 0; i < N; i++) check_region_outs(i, "R4 outs");
    bus_write(8'h04, 32'h0000_0003);
    check_region_outs(1, "R6 reserved code");
    bus_read(8'h04, "R6 reserved stored");

    // R9: undecoded offsets
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h02, 32'h0000_0000);
    bus_write(8'h24, 32'h0000_0001);
    bus_write(8'h1C, 32'h0000_00AA);
    read_all("R9 after miss write");
    bus_read(8'h10, "R9 miss read");
    bus_read(8'h21, "R9 misaligned read");
    bus_read(8'hFC, "R9 high read");
    @(negedge clk);
    check("R9 guard kept open", 32'(bank_locked), 32'h0);

    // R3: non-key values close
    bus_write(8'h20, 32'h0001A05F);
    @(negedge clk);
    check("R3 upper-bit key", 32'(bank_locked), 32'h1);
    bus_write(8'h08, 32'h0000_0055);
    bus_read(8'h08, "R3 refused after close");
    bus_write(8'h20, 32'h0000A05F);
    bus_write(8'h20, 32'h0000_0000);
    @(negedge clk);
    check("R3 zero closes", 32'(bank_locked), 32'h1);
    bus_write(8'h20, 32'h0000A05F);
    bus_write(8'h20, 32'h0000_0001);
    bus_read(8'h20, "R3 one closes");
    bus_write(8'h20, 32'h0000A05E);
    bus_read(8'h20, "R3 near key");

    // R10: back-to-back write then read sees new value
    bus_write(8'h20, 32'h0000A05F);
    bus_write(8'h0C, 32'h0000_0068);
    bus_read(8'h0C, "R10 read after write");
    check_region_outs(3, "R10 outs");

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 32'(sb_q.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule